// File: doc/BRIEF.md
# Seeded Lane Byte Scrambler with Control-Character Resync

This block whitens one byte lane ahead of an 8b/10b encoder. A second copy of the same module sits after the decoder and undoes the whitening. Each cycle it accepts a byte, a flag marking the byte as a control character, and a valid strobe. Data bytes are XORed with keystream from a 7-bit linear feedback shift register. Control bytes are forwarded unchanged. The result appears one clock later, and the valid and control flags are delayed to match.

Both ends stay aligned without any training sequence. A comma-class control character, with code 0x3C, 0xBC or 0xFC and the control flag set, reloads the register from a per-lane seed input. A seed of zero would lock the register, so the block replaces it with all ones. A runtime enable lets bytes pass straight through when scrambling is not wanted. The descrambling copy must be given the same seed as the transmitting copy.

Top module: `lane_scrambler`

## Requirements
- R1: With enable=1 and a valid data byte (ctrl_in=0), output bit i equals data_in[i] XOR k_i for i = 0..7, taken LSB first. Each k_i is produced by one step of the register s[6:0]: k = s[6] XOR s[5], then s becomes {s[5:0], k}. This is the polynomial x^7 + x^6 + 1.
- R2: The register advances exactly 8 steps per scrambled data byte. The keystream therefore repeats after 127 data bytes, so output byte 128 of an all-zero stream equals output byte 1.
- R3: A valid byte with ctrl_in=1 is output unchanged. If its code is not a sync code, the register state is left as it was.
- R4: A valid byte with ctrl_in=1 and code 0x3C, 0xBC or 0xFC reloads the register from the seed, whatever the enable setting. The same codes with ctrl_in=0 are scrambled as ordinary data.
- R5: A seed of 7'h00 acts as 7'h7F, both at reset and on reload.
- R6: With enable=0, valid data bytes are output unchanged and the register does not advance.
- R7: Outputs are registered with one cycle of latency. valid_out and ctrl_out equal valid_in and ctrl_in from the previous cycle.
- R8: When valid_in=0 the register state holds.
- R9: Synchronous active-high reset loads the seed (after R5 substitution) and drives valid_out, ctrl_out and data_out to 0.
- R10: A scrambling copy feeding a descrambling copy with the same seed and enable returns the original byte, control flag and valid stream bit-exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | 1 = scramble data bytes, 0 = pass through |
| seed | input | 7 | Per-lane register seed |
| valid_in | input | 1 | Input byte valid |
| ctrl_in | input | 1 | Input byte is a control character |
| data_in | input | 8 | Input byte |
| valid_out | output | 1 | Output byte valid |
| ctrl_out | output | 1 | Delayed control flag |
| data_out | output | 8 | Processed byte |

## Verification
The hardest situation to reach from the ports is a register state that has drifted a long way from the seed before a resync lands. That is where a wrong reload or a missed hold would show. The bench sweeps all 128 seeds, including the illegal zero. Each run mixes data bytes, non-sync control bytes and a sync character placed mid-stream. A separate run covers every one of the 256 data values from a single state, and another pushes 128 zero bytes through to close the full keystream period. Valid gaps and enable toggles are placed between bytes. Every output is compared with an arithmetic model of the register, and the descrambler output is compared with the original stream.

// File: rtl/lane_scr_pkg.sv
package lane_scr_pkg;
  localparam int NUM_SYNC = 3;
  localparam int CODE_W   = 8;
  // Comma-class control codes that resynchronise the keystream
  localparam logic [NUM_SYNC*CODE_W-1:0] SYNC_CODES = {8'hFC, 8'hBC, 8'h3C};
endpackage

// File: rtl/scr_keystream.sv
// Combinational multi-step advance of a two-tap Fibonacci register.
module scr_keystream #(
  parameter int LFSR_W = 7,
  parameter int STEPS  = 8,
  parameter int TAP_HI = 6,
  parameter int TAP_LO = 5
) (
  input  logic [LFSR_W-1:0] state_i,
  output logic [STEPS-1:0]  key_o,
  output logic [LFSR_W-1:0] next_o
);
  logic [LFSR_W-1:0] s;
  logic              kb;

  always_comb begin
    s  = state_i;
    kb = 1'b0;
    key_o = '0;
    for (int i = 0; i < STEPS; i++) begin
      kb       = s[TAP_HI] ^ s[TAP_LO];
      key_o[i] = kb;
      s        = {s[LFSR_W-2:0], kb};
    end
    next_o = s;
  end
endmodule

// File: rtl/scr_sync_detect.sv
// Flags control bytes whose code is one of the resync codes.
module scr_sync_detect
  import lane_scr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] code_i,
  output logic              sync_o
);
  logic [NUM_SYNC-1:0] hit;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_cmp
    assign hit[g] = (code_i == SYNC_CODES[g*CODE_W +: CODE_W]);
  end

  assign sync_o = ctrl_i & (|hit);
endmodule

// File: rtl/scr_seed_fix.sv
// Replaces the lock-up seed (all zero) with all ones.
module scr_seed_fix #(
  parameter int LFSR_W = 7
) (
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] seed_o
);
  assign seed_o = (seed_i == '0) ? {LFSR_W{1'b1}} : seed_i;
endmodule

// File: rtl/lane_scrambler.sv
module lane_scrambler #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [LFSR_W-1:0] seed,
  input  logic              valid_in,
  input  logic              ctrl_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid_out,
  output logic              ctrl_out,
  output logic [DATA_W-1:0] data_out
);
  localparam int TAP_HI = LFSR_W - 1;
  localparam int TAP_LO = LFSR_W - 2;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_nxt;
  logic [LFSR_W-1:0] seed_eff;
  logic [DATA_W-1:0] key;
  logic              is_sync;
  logic              valid_q;
  logic              ctrl_q;
  logic [DATA_W-1:0] data_q;

  scr_seed_fix #(.LFSR_W(LFSR_W)) u_seed (
    .seed_i (seed),
    .seed_o (seed_eff)
  );

  scr_keystream #(
    .LFSR_W (LFSR_W),
    .STEPS  (DATA_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO)
  ) u_key (
    .state_i (lfsr_q),
    .key_o   (key),
    .next_o  (lfsr_nxt)
  );

  scr_sync_detect #(.DATA_W(DATA_W)) u_sync (
    .ctrl_i (ctrl_in),
    .code_i (data_in),
    .sync_o (is_sync)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q  <= seed_eff;
      valid_q <= 1'b0;
      ctrl_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_in;
      ctrl_q  <= ctrl_in;
      data_q  <= data_in;
      if (valid_in) begin
        if (ctrl_in) begin
          if (is_sync) lfsr_q <= seed_eff;
        end else if (enable) begin
          data_q <= data_in ^ key;
          lfsr_q <= lfsr_nxt;
        end
      end
    end
  end

  assign valid_out = valid_q;
  assign ctrl_out  = ctrl_q;
  assign data_out  = data_q;
endmodule

// File: rtl/lane_scrambler_chk.sv
module lane_scrambler_chk #(
  parameter int DATA_W = 8,
  parameter int LFSR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [LFSR_W-1:0] seed,
  input logic              valid_in,
  input logic              ctrl_in,
  input logic [DATA_W-1:0] data_in,
  input logic              valid_out,
  input logic              ctrl_out,
  input logic [DATA_W-1:0] data_out,
  input logic [LFSR_W-1:0] lfsr_q
);
  logic in_sync;
  assign in_sync = valid_in && ctrl_in &&
                   (data_in == 8'h3C || data_in == 8'hBC || data_in == 8'hFC);

  assert_ctrl_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_in && ctrl_in) |=> (data_out == $past(data_in)));

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_in && ctrl_in && !in_sync) |=> $stable(lfsr_q));

  assert_sync_reload_R4: assert property (@(posedge clk) disable iff (rst)
    in_sync |=> (lfsr_q == (($past(seed) == '0) ? {LFSR_W{1'b1}} : $past(seed))));

  assert_never_zero_R5: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !ctrl_in && !enable) |=> (data_out == $past(data_in) && $stable(lfsr_q)));

  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (valid_out == $past(valid_in) && ctrl_out == $past(ctrl_in)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(lfsr_q));

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (!valid_out && !ctrl_out && data_out == '0));
endmodule

bind lane_scrambler lane_scrambler_chk #(.DATA_W(DATA_W), .LFSR_W(LFSR_W)) u_chk (.*);

// File: tb/sim_lane_scrambler.sv
`timescale 1ns/1ps
module sim_lane_scrambler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b1;
  logic [6:0] seed = 7'h01;
  logic       vin = 1'b0, cin = 1'b0;
  logic [7:0] din = 8'h00;
  logic       v0, c0, v1, c1;
  logic [7:0] d0, d1;

  int checks = 0, errors = 0, cyc = 0;
  logic [6:0] mst;
  logic       pv; logic pc; logic [7:0] pd;
  logic [7:0] first_out, last_out;

  always #4 clk = ~clk;

  lane_scrambler u0 (.clk(clk), .rst(rst), .enable(en), .seed(seed),
    .valid_in(vin), .ctrl_in(cin), .data_in(din),
    .valid_out(v0), .ctrl_out(c0), .data_out(d0));

  lane_scrambler u1 (.clk(clk), .rst(rst), .enable(en), .seed(seed),
    .valid_in(v0), .ctrl_in(c0), .data_in(d0),
    .valid_out(v1), .ctrl_out(c1), .data_out(d1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] fix(input logic [6:0] s);
    return (s == 7'h00) ? 7'h7F : s;
  endfunction

  // Model: returns {next_state, key_byte}
  function automatic logic [14:0] mdl(input logic [6:0] s);
    logic [7:0] k; logic b; logic [6:0] t;
    t = s; k = '0;
    for (int i = 0; i < 8; i++) begin
      b = t[6] ^ t[5];
      k[i] = b;
      t = {t[5:0], b};
    end
    return {t, k};
  endfunction

  task automatic do_reset();
    rst = 1'b1; vin = 1'b0;
    @(negedge clk);
    chk(v0 == 1'b0 && c0 == 1'b0 && d0 == 8'h00, "R9 reset outputs", {v0, c0, d0}, 0);
    chk(v1 == 1'b0, "R9 reset valid descrambler", v1, 0);
    mst = fix(seed); pv = 1'b0; pc = 1'b0; pd = '0;
    rst = 1'b0;
  endtask

  // Drive at a falling edge, check one cycle later at the next falling edge
  task automatic step(input logic [7:0] d, input logic c, input logic v, input string tag);
    logic [7:0] exp; logic [14:0] r;
    din = d; cin = c; vin = v;
    exp = d;
    if (v) begin
      if (c) begin
        if (d == 8'h3C || d == 8'hBC || d == 8'hFC) mst = fix(seed);
      end else if (en) begin
        r = mdl(mst);
        exp = d ^ r[7:0];
        mst = r[14:8];
      end
    end
    @(negedge clk);
    chk(v0 == v, {tag, " R7 valid delay"}, v0, v);
    if (v) begin
      chk(c0 == c, {tag, " R7 ctrl delay"}, c0, c);
      chk(d0 == exp, {tag, " data"}, d0, exp);
      last_out = d0;
    end
    chk(v1 == pv, {tag, " R10 valid roundtrip"}, v1, pv);
    if (pv) begin
      chk(d1 == pd && c1 == pc, {tag, " R10 roundtrip"}, {c1, d1}, {pc, pd});
    end
    pv = v; pc = c; pd = d;
  endtask

  initial begin
    @(negedge clk);
    // Sweep every seed (zero seed covers R5) with mixed traffic (R1 R3 R4 R8)
    for (int s = 0; s < 128; s++) begin
      seed = s[6:0];
      do_reset();
      for (int i = 0; i < 24; i++) begin
        if (i == 6)       step(8'h1C, 1'b1, 1'b1, "R3 non-sync ctrl");
        else if (i == 9)  step(8'h55, 1'b0, 1'b0, "R8 idle gap");
        else if (i == 14) step(8'hBC, 1'b1, 1'b1, "R4 sync reload");
        else if (i == 18) step(8'h3C, 1'b1, 1'b1, "R4 sync reload 3C");
        else              step(8'((s * 37 + i * 11) & 255), 1'b0, 1'b1, "R1 R5 seed sweep");
      end
    end
    // Every data value from one seed (R1)
    seed = 7'h05;
    do_reset();
    for (int d = 0; d < 256; d++) step(d[7:0], 1'b0, 1'b1, "R1 all bytes");
    // Sync codes sent as data are scrambled (R4), K28.7 reload
    for (int i = 0; i < 3; i++) begin
      step(8'h3C, 1'b0, 1'b1, "R4 code as data");
      step(8'hBC, 1'b0, 1'b1, "R4 code as data");
      step(8'hFC, 1'b0, 1'b1, "R4 code as data");
    end
    step(8'hFC, 1'b1, 1'b1, "R4 sync FC");
    step(8'h00, 1'b0, 1'b1, "R4 after FC");
    // Full period (R2)
    seed = 7'h2A;
    do_reset();
    step(8'h00, 1'b0, 1'b1, "R2 period");
    first_out = last_out;
    for (int i = 0; i < 126; i++) step(8'h00, 1'b0, 1'b1, "R2 period");
    step(8'h00, 1'b0, 1'b1, "R2 period");
    chk(last_out == first_out, "R2 byte 128 equals byte 1", last_out, first_out);
    // Bypass: enable low passes bytes and holds state, sync still reloads (R6)
    step(8'h00, 1'b0, 1'b0, "R6 idle");
    step(8'h00, 1'b0, 1'b0, "R6 idle");
    en = 1'b0;
    for (int i = 0; i < 20; i++) step(8'(i * 13), 1'b0, 1'b1, "R6 bypass");
    step(8'hBC, 1'b1, 1'b1, "R6 sync while off");
    step(8'h00, 1'b0, 1'b0, "R6 idle");
    step(8'h00, 1'b0, 1'b0, "R6 idle");
    en = 1'b1;
    for (int i = 0; i < 16; i++) step(8'(i * 29 + 1), 1'b0, 1'b1, "R6 resume");
    step(8'h00, 1'b0, 1'b0, "R10 drain");
    step(8'h00, 1'b0, 1'b0, "R10 drain");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule